// File: doc/BRIEF.md
# Black Level Offset Loop

This block closes a slow digital loop around the offset DACs of a three-channel video digitizer. In the blanking interval after each sync pulse, a strobe marks which ADC samples show the black level. The block sums those samples per channel over a fixed group of lines. At the end of each group it compares the mean black level with a per-channel target, at quarter-code resolution. It then moves that channel's 10-bit offset DAC code by at most one step. One DAC step is worth a quarter of an 8-bit ADC code, so the correction stays too small and too slow to be seen on screen.

The target is ADC code 0 for every channel in RGB mode. In colour-difference mode the red and blue channels carry bipolar signals, so their target moves to mid-scale. An 8-bit trim register per channel shifts the target by whole ADC codes. When the loop is disabled, firmware drives the DAC codes directly. When it is re-enabled, the loop resumes from the last firmware code. A lock flag reports that the black levels have stayed inside the dead band for several groups in a row.

Top module: `black_level_loop`

## Requirements
- R1: After reset, all three DAC codes are 512 and `locked` is 0.
- R2: While `loop_en` is 0, each DAC code equals its `fw_*` input, sampled one clock earlier, and `locked` is 0. Re-enabling the loop continues from those codes.
- R3: Samples are accumulated in every cycle where `bp_valid` is 1. An evaluation happens on the 16th `line_strobe` pulse after the last restart or evaluation. DAC codes change only in the clock that follows an evaluation.
- R4: A higher DAC code raises the black level. At an evaluation, let d be 4·(mean of the accumulated samples) − 4·target. If d > 1, the code drops by 1. If d < −1, the code rises by 1. If |d| ≤ 1 (the dead band), the code is unchanged. A group with no samples leaves the code unchanged.
- R5: With `yuv_mode` = 0, the base target is 0 on all channels. With `yuv_mode` = 1, the base target is 128 on the red channel (V) and the blue channel (U), and 0 on the green channel (Y).
- R6: The target is the base plus (trim − 128) ADC codes, where trim is the channel's `trim_*` input. The shift is clamped to the range −64 to +64.
- R7: DAC codes saturate: a code of 0 never steps down, and a code of 1023 never steps up.
- R8: `locked` rises after 4 consecutive evaluations in which all three channels were inside the dead band. Any evaluation where some channel was outside the band clears it.
- R9: A change of any `trim_*` input or of `yuv_mode` clears `locked` in the next clock. It also discards the partial accumulation, so that a full 16 lines follow before the next evaluation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_en | input | 1 | 1 = automatic loop, 0 = firmware codes |
| yuv_mode | input | 1 | 1 = colour-difference targets on red and blue |
| bp_valid | input | 1 | Current ADC samples lie in the black window |
| line_strobe | input | 1 | One-cycle pulse per video line |
| adc_red | input | 8 | Red / V channel ADC sample |
| adc_grn | input | 8 | Green / Y channel ADC sample |
| adc_blu | input | 8 | Blue / U channel ADC sample |
| trim_red | input | 8 | Red target trim, 128 = none |
| trim_grn | input | 8 | Green target trim, 128 = none |
| trim_blu | input | 8 | Blue target trim, 128 = none |
| fw_red | input | 10 | Firmware DAC code, red |
| fw_grn | input | 10 | Firmware DAC code, green |
| fw_blu | input | 10 | Firmware DAC code, blue |
| dac_red | output | 10 | Offset DAC code, red |
| dac_grn | output | 10 | Offset DAC code, green |
| dac_blu | output | 10 | Offset DAC code, blue |
| locked | output | 1 | Black levels settled |

## Verification
The bench feeds line patterns whose mean sits exactly on the dead-band edge (a quarter code off) and just past it (half a code off). A comparator that lost the fractional bits, or had the wrong inequality, would step one case it should hold or hold one it should step. A configuration change is made halfway through a group, and the codes are checked after 15 further lines. A loop that kept its stale line count would step early on old data. Trims at 0x00 and 0xFF check the ±64 clamp, and codes at 0 and 1022 are pushed into the rails. A design without the clamp, or with a wrapping code, would land on a visibly wrong value.

// File: rtl/bll_pkg.sv
package bll_pkg;

    parameter int ADC_W     = 8;   // ADC sample width
    parameter int DAC_W     = 10;  // offset DAC code width
    parameter int CNT_W     = 12;  // sample counter width per group
    parameter int FRAC_W    = 2;   // DAC step = 2^-FRAC_W ADC code
    parameter int TRIM_SPAN = 64;  // trim clamp, whole ADC codes

    localparam int SUM_W   = ADC_W + CNT_W;
    localparam int ADC_MID = 1 << (ADC_W - 1);
    localparam logic [DAC_W-1:0] DAC_MAX = '1;
    localparam logic [DAC_W-1:0] DAC_MID = {1'b1, {(DAC_W-1){1'b0}}};

    typedef enum logic [1:0] {CH_RED = 2'd0, CH_GRN = 2'd1, CH_BLU = 2'd2} chan_e;
    typedef enum logic [1:0] {DIR_HOLD, DIR_UP, DIR_DOWN} dir_e;

    typedef struct packed {
        logic [SUM_W-1:0] sum;
        logic [CNT_W-1:0] cnt;
    } acc_t;

    // Target in fractional ADC units (ADC code << FRAC_W)
    function automatic int target_q(chan_e ch, logic yuv, logic [ADC_W-1:0] trim);
        int base;
        int delta;
        base  = (yuv && ch != CH_GRN) ? ADC_MID : 0;
        delta = int'(trim) - ADC_MID;
        if (delta > TRIM_SPAN)
            delta = TRIM_SPAN;
        else if (delta < -TRIM_SPAN)
            delta = -TRIM_SPAN;
        return (base + delta) * (1 << FRAC_W);
    endfunction

    // Compare mean with target without division: scale both by the count
    function automatic dir_e decide(acc_t a, int tq);
        int band;
        int err;
        band = int'(a.cnt);
        err  = int'(a.sum) * (1 << FRAC_W) - band * tq;
        if (err > band)
            return DIR_DOWN;
        if (err < -band)
            return DIR_UP;
        return DIR_HOLD;
    endfunction

endpackage

// File: rtl/bll_chan.sv
module bll_chan
    import bll_pkg::*;
#(
    parameter chan_e CH = CH_RED
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             eval,
    input  logic             loop_en,
    input  logic             bp_valid,
    input  logic             yuv,
    input  logic [ADC_W-1:0] adc,
    input  logic [ADC_W-1:0] trim,
    input  logic [DAC_W-1:0] fw_code,
    output logic [DAC_W-1:0] code,
    output logic             in_range
);

    acc_t             acc_q;
    acc_t             acc_nxt;
    dir_e             dir;
    logic [DAC_W-1:0] code_q;

    always_comb begin
        acc_nxt.sum = acc_q.sum + (bp_valid ? SUM_W'(adc) : '0);
        acc_nxt.cnt = acc_q.cnt + CNT_W'(bp_valid);
        dir         = decide(acc_nxt, target_q(CH, yuv, trim));
        in_range    = (dir == DIR_HOLD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            code_q <= DAC_MID;
        end else begin
            if (restart || eval)
                acc_q <= '0;
            else
                acc_q <= acc_nxt;

            if (!loop_en)
                code_q <= fw_code;
            else if (eval) begin
                if (dir == DIR_UP && code_q != DAC_MAX)
                    code_q <= code_q + DAC_W'(1);
                else if (dir == DIR_DOWN && code_q != '0)
                    code_q <= code_q - DAC_W'(1);
            end
        end
    end

    assign code = code_q;

    // R3: no movement between evaluations while the loop runs
    a_r3_code_quiet: assert property (@(posedge clk) disable iff (rst)
        (loop_en && $past(loop_en) && !$past(eval)) |-> $stable(code_q));

    // R4: at most one step per evaluation
    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
        (loop_en && $past(loop_en)) |->
            (code_q == $past(code_q) ||
             code_q == $past(code_q) + DAC_W'(1) ||
             code_q == $past(code_q) - DAC_W'(1)));

    // R7: the lower rail never wraps to the top
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (loop_en && $past(loop_en) && $past(code_q) == '0) |-> code_q != DAC_MAX);

endmodule

// File: rtl/bll_seq.sv
module bll_seq
    import bll_pkg::*;
#(
    parameter int LINES_LOG2 = 4,
    parameter int LOCK_N     = 4,
    parameter int CFG_W      = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             loop_en,
    input  logic             line_strobe,
    input  logic [CFG_W-1:0] cfg,
    input  logic             all_in_range,
    output logic             restart,
    output logic             eval,
    output logic             locked
);

    localparam int QW = $clog2(LOCK_N + 1);

    logic [CFG_W-1:0]      cfg_q;
    logic [LINES_LOG2-1:0] line_q;
    logic [QW-1:0]         quiet_q;

    assign restart = !loop_en || (cfg != cfg_q);
    assign eval    = line_strobe && (line_q == '1) && !restart;
    assign locked  = (quiet_q == QW'(LOCK_N));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= cfg;
            line_q  <= '0;
            quiet_q <= '0;
        end else begin
            cfg_q <= cfg;
            if (restart) begin
                line_q  <= '0;
                quiet_q <= '0;
            end else begin
                if (line_strobe)
                    line_q <= line_q + LINES_LOG2'(1);
                if (eval) begin
                    if (!all_in_range)
                        quiet_q <= '0;
                    else if (quiet_q != QW'(LOCK_N))
                        quiet_q <= quiet_q + QW'(1);
                end
            end
        end
    end

    // R8: lock is only gained at an evaluation
    a_r8_lock_on_eval: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(eval));

    // R9: any restart drops lock in the following clock
    a_r9_restart_unlocks: assert property (@(posedge clk) disable iff (rst)
        restart |=> !locked);

endmodule

// File: rtl/black_level_loop.sv
module black_level_loop
    import bll_pkg::*;
#(
    parameter int LINES_LOG2 = 4,
    parameter int LOCK_N     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             loop_en,
    input  logic             yuv_mode,
    input  logic             bp_valid,
    input  logic             line_strobe,
    input  logic [ADC_W-1:0] adc_red,
    input  logic [ADC_W-1:0] adc_grn,
    input  logic [ADC_W-1:0] adc_blu,
    input  logic [ADC_W-1:0] trim_red,
    input  logic [ADC_W-1:0] trim_grn,
    input  logic [ADC_W-1:0] trim_blu,
    input  logic [DAC_W-1:0] fw_red,
    input  logic [DAC_W-1:0] fw_grn,
    input  logic [DAC_W-1:0] fw_blu,
    output logic [DAC_W-1:0] dac_red,
    output logic [DAC_W-1:0] dac_grn,
    output logic [DAC_W-1:0] dac_blu,
    output logic             locked
);

    localparam int NCH   = 3;
    localparam int CFG_W = 1 + NCH * ADC_W;

    logic [ADC_W-1:0] adc_a  [NCH];
    logic [ADC_W-1:0] trim_a [NCH];
    logic [DAC_W-1:0] fw_a   [NCH];
    logic [DAC_W-1:0] code_a [NCH];
    logic [NCH-1:0]   ok_a;
    logic             restart;
    logic             eval;

    assign adc_a  = '{adc_red, adc_grn, adc_blu};
    assign trim_a = '{trim_red, trim_grn, trim_blu};
    assign fw_a   = '{fw_red, fw_grn, fw_blu};

    bll_seq #(
        .LINES_LOG2 (LINES_LOG2),
        .LOCK_N     (LOCK_N),
        .CFG_W      (CFG_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .loop_en      (loop_en),
        .line_strobe  (line_strobe),
        .cfg          ({yuv_mode, trim_red, trim_grn, trim_blu}),
        .all_in_range (&ok_a),
        .restart      (restart),
        .eval         (eval),
        .locked       (locked)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        bll_chan #(
            .CH (chan_e'(gi))
        ) u_chan (
            .clk      (clk),
            .rst      (rst),
            .restart  (restart),
            .eval     (eval),
            .loop_en  (loop_en),
            .bp_valid (bp_valid),
            .yuv      (yuv_mode),
            .adc      (adc_a[gi]),
            .trim     (trim_a[gi]),
            .fw_code  (fw_a[gi]),
            .code     (code_a[gi]),
            .in_range (ok_a[gi])
        );
    end

    assign dac_red = code_a[0];
    assign dac_grn = code_a[1];
    assign dac_blu = code_a[2];

endmodule

// File: tb/black_level_loop_tb.sv
module black_level_loop_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst, loop_en, yuv_mode, bp_valid, line_strobe;
    logic [7:0] adc_red, adc_grn, adc_blu;
    logic [7:0] trim_red, trim_grn, trim_blu;
    logic [9:0] fw_red, fw_grn, fw_blu;
    logic [9:0] dac_red, dac_grn, dac_blu;
    logic       locked;

    black_level_loop u_dut (
        .clk(clk), .rst(rst), .loop_en(loop_en), .yuv_mode(yuv_mode),
        .bp_valid(bp_valid), .line_strobe(line_strobe),
        .adc_red(adc_red), .adc_grn(adc_grn), .adc_blu(adc_blu),
        .trim_red(trim_red), .trim_grn(trim_grn), .trim_blu(trim_blu),
        .fw_red(fw_red), .fw_grn(fw_grn), .fw_blu(fw_blu),
        .dac_red(dac_red), .dac_grn(dac_grn), .dac_blu(dac_blu),
        .locked(locked)
    );

    typedef struct packed {
        logic [9:0] r;
        logic [9:0] g;
        logic [9:0] b;
        logic       lk;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // reference model state
    int m_code[3];
    int m_trim[3];
    int m_quiet;
    bit m_yuv;

    task automatic push(input string tag);
        exp_q.push_back({10'(m_code[0]), 10'(m_code[1]), 10'(m_code[2]), m_quiet >= 4});
        tag_q.push_back(tag);
    endtask

    // monitor: compare queued expectations away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if ({dac_red, dac_grn, dac_blu, locked} !== e) begin
                    n_fail++;
                    $display("FAIL %s: got r=%0d g=%0d b=%0d lock=%0b, expected r=%0d g=%0d b=%0d lock=%0b",
                             t, dac_red, dac_grn, dac_blu, locked, e.r, e.g, e.b, e.lk);
                end
            end
        end
    end

    function automatic int tgt(input int ch);
        int base;
        int d;
        base = (m_yuv && ch != 1) ? 128 : 0;
        d = m_trim[ch] - 128;
        if (d > 64) d = 64;
        if (d < -64) d = -64;
        return base + d;
    endfunction

    // one group: every line has 4 samples, k of them at v+1, the rest at v
    task automatic model_eval(input int vr, kr, vg, kg, vb, kb);
        int v[3];
        int k[3];
        bit all_ok;
        v = '{vr, vg, vb};
        k = '{kr, kg, kb};
        all_ok = 1'b1;
        for (int c = 0; c < 3; c++) begin
            int d;
            d = 4 * v[c] + k[c] - 4 * tgt(c);
            if (d > 1) begin
                all_ok = 1'b0;
                if (m_code[c] > 0) m_code[c]--;
            end else if (d < -1) begin
                all_ok = 1'b0;
                if (m_code[c] < 1023) m_code[c]++;
            end
        end
        if (!all_ok) m_quiet = 0;
        else if (m_quiet < 4) m_quiet++;
    endtask

    task automatic run_lines(input int n, input int vr, kr, vg, kg, vb, kb);
        for (int l = 0; l < n; l++) begin
            for (int s = 0; s < 4; s++) begin
                @(negedge clk);
                bp_valid = 1'b1;
                adc_red = 8'(vr + ((s < kr) ? 1 : 0));
                adc_grn = 8'(vg + ((s < kg) ? 1 : 0));
                adc_blu = 8'(vb + ((s < kb) ? 1 : 0));
            end
            @(negedge clk);
            bp_valid = 1'b0;
            adc_red = 8'd0; adc_grn = 8'd0; adc_blu = 8'd0;
            @(negedge clk);
            line_strobe = 1'b1;
            @(negedge clk);
            line_strobe = 1'b0;
        end
    endtask

    task automatic interval(input int vr, kr, vg, kg, vb, kb, input string tag);
        run_lines(16, vr, kr, vg, kg, vb, kb);
        model_eval(vr, kr, vg, kg, vb, kb);
        push(tag);
    endtask

    task automatic set_cfg(input int tr, tg, tb, input bit y, input string tag);
        @(negedge clk);
        trim_red = 8'(tr); trim_grn = 8'(tg); trim_blu = 8'(tb); yuv_mode = y;
        m_trim = '{tr, tg, tb};
        m_yuv = y;
        m_quiet = 0;
        @(negedge clk);
        push(tag);
    endtask

    task automatic summary;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; loop_en = 1'b1; yuv_mode = 1'b0;
        bp_valid = 1'b0; line_strobe = 1'b0;
        adc_red = 8'd0; adc_grn = 8'd0; adc_blu = 8'd0;
        trim_red = 8'h80; trim_grn = 8'h80; trim_blu = 8'h80;
        fw_red = 10'd0; fw_grn = 10'd0; fw_blu = 10'd0;
        m_code = '{512, 512, 512};
        m_trim = '{128, 128, 128};
        m_quiet = 0;
        m_yuv = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        push("R1 reset state");

        // RGB targets all 0, black exactly on target: lock after 4 groups
        interval(0, 0, 0, 0, 0, 0, "R5/R8 quiet group 1");
        interval(0, 0, 0, 0, 0, 0, "R5/R8 quiet group 2");
        interval(0, 0, 0, 0, 0, 0, "R5/R8 quiet group 3");
        interval(0, 0, 0, 0, 0, 0, "R8 lock after group 4");

        // dead band edge (+1/4) holds, half code high steps down, lock drops
        interval(0, 1, 0, 2, 0, 0, "R4/R8 band edge and step down");

        // raised green target: half code low steps up, quarter low holds
        set_cfg(128, 144, 128, 1'b0, "R9 trim change");
        interval(0, 0, 15, 2, 0, 0, "R4/R6 step up");
        interval(0, 0, 15, 3, 0, 0, "R4 lower band edge");

        // relock, then a trim change must drop the flag
        interval(0, 0, 16, 0, 0, 0, "R8 relock 1");
        interval(0, 0, 16, 0, 0, 0, "R8 relock 2");
        interval(0, 0, 16, 0, 0, 0, "R8 relock 3");
        interval(0, 0, 16, 0, 0, 0, "R8 relock 4");
        set_cfg(128, 145, 128, 1'b0, "R9 trim change clears lock");

        // clamp of the trim at +64 and -64
        set_cfg(255, 0, 128, 1'b0, "R9 cfg");
        interval(64, 0, 0, 0, 0, 0, "R6 trim clamp");

        // colour-difference mode: mid-scale targets on red and blue
        set_cfg(128, 128, 128, 1'b1, "R9 mode change");
        interval(128, 0, 0, 0, 128, 0, "R5 YUV mid-scale hold");
        interval(128, 2, 0, 0, 127, 2, "R5 YUV steps");

        // restart in the middle of a group
        set_cfg(128, 128, 128, 1'b0, "R9 mode back");
        run_lines(8, 3, 0, 0, 0, 0, 0);
        set_cfg(128, 129, 128, 1'b0, "R9 mid-group change");
        run_lines(15, 3, 0, 1, 0, 0, 0);
        push("R3/R9 no step after 15 lines");
        run_lines(1, 3, 0, 1, 0, 0, 0);
        model_eval(3, 0, 1, 0, 0, 0);
        push("R3 step on 16th line");

        // firmware control
        @(negedge clk);
        loop_en = 1'b0;
        fw_red = 10'd0; fw_grn = 10'd700; fw_blu = 10'd1022;
        m_code = '{0, 700, 1022};
        m_quiet = 0;
        @(negedge clk);
        push("R2 firmware codes");
        fw_grn = 10'd701;
        m_code[1] = 701;
        @(negedge clk);
        push("R2 firmware follow");

        // rails: red pushed down at 0, blue pushed up toward 1023
        set_cfg(128, 128, 192, 1'b0, "R9 cfg while disabled");
        @(negedge clk);
        loop_en = 1'b1;
        interval(5, 0, 0, 0, 0, 0, "R7 saturation 1");
        interval(5, 0, 0, 0, 0, 0, "R7 saturation 2");

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule